// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control word of each downstream port on a full/low-speed root hub. Software reads a port's word through a combinational read index and updates it through a single-cycle write strobe. The hardware side supplies a level for device presence, a level for the device's speed class, and a wakeup strobe for each port.

Presence edges are turned into connect and enable bookkeeping. The word mixes three bit policies. Hardware-owned bits ignore writes. Two change flags clear only when a one is written to them. All remaining bits take the written value. Setting the bus-reset bit from zero produces a one-cycle reset pulse toward the attached device. Transaction routing uses the enabled bit of each port, and a wakeup from a suspended port raises a resume request to the host controller.

The number of ports and the width of the port index are parameters. An index with no port behind it reads back a fixed pattern, and a write to such an index is ignored.

Top module: `rhp_root_ports`

## Requirements
- R1: Each port word is 16 bits with this layout: bit 0 device connected, bit 1 connect changed, bit 2 port enabled, bit 3 enable changed, bit 6 resume detected, bit 8 low-speed device, bit 9 bus reset, bit 12 suspended. The word reads back combinationally on `rd_data` for the port selected by `rd_idx`.
- R2: A write keeps the bits in mask 0x01BB (bits 0,1,3,4,5,7,8) at their previous value. Every other bit takes the written value. Bits 4, 5 and 7 are always read as 0.
- R3: Writing 1 to bit 1 or bit 3 clears that bit. Writing 0 to either bit leaves it unchanged.
- R4: A write that sets bit 9 while bit 9 is 0 drives that port's `bus_reset_pulse` high for exactly one cycle, in the cycle after the write edge. A write of 1 while bit 9 is already 1 produces no pulse.
- R5: A rising edge of `dev_present` sets bits 0 and 1. It also loads bit 8 from `dev_low_speed`, which is 1 for a low-speed device.
- R6: A falling edge of `dev_present` clears bit 0 and sets bit 1 if bit 0 was set. It clears bit 2 and sets bit 3 if bit 2 was set. Bit 8 is not changed.
- R7: A `dev_wakeup` strobe while bit 12 is 1 and bit 6 is 0 sets bit 6 and raises `resume_req` for one cycle in the cycle after the strobe. In any other state, the strobe changes nothing.
- R8: Reading an index at or above NUM_PORTS returns 0xFF7F. Writing to such an index changes no port.
- R9: `port_enabled[i]` always equals bit 2 of port i's word.
- R10: Reset clears every word to 0 and clears the pulse outputs. A device still present after reset is attached again on the first clock after release, as in R5.
- R11: Within one cycle, a write is applied first, then attach or detach, then wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_idx | input | IDX_W | Port index of the write |
| wr_data | input | 16 | Write data |
| rd_idx | input | IDX_W | Port index of the read |
| rd_data | output | 16 | Selected port word, or 0xFF7F if the index has no port |
| dev_present | input | NUM_PORTS | Device present level for each port |
| dev_low_speed | input | NUM_PORTS | Speed class of the attached device, 1 = low speed |
| dev_wakeup | input | NUM_PORTS | Remote-wakeup strobe for each port |
| bus_reset_pulse | output | NUM_PORTS | One-cycle bus-reset request for each port |
| port_enabled | output | NUM_PORTS | Port may carry transactions |
| resume_req | output | 1 | One-cycle resume request to the host controller |

## Verification
The bench builds the block with NUM_PORTS = 2 and IDX_W = 3. With two ports, one port can hold a full-speed device and the other a low-speed device, and the bench can check that a write, pulse or detach on one port leaves the other alone. The 3-bit index reaches values up to 7, so reads and writes to indexes 2 through 7, which have no port, fall inside the tested range.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  localparam int REG_W      = 16;
  localparam int B_CONN     = 0;
  localparam int B_CONN_CHG = 1;
  localparam int B_EN       = 2;
  localparam int B_EN_CHG   = 3;
  localparam int B_RESUME   = 6;
  localparam int B_LOWSPD   = 8;
  localparam int B_BUSRST   = 9;
  localparam int B_SUSP     = 12;

  localparam logic [REG_W-1:0] HW_OWNED_MASK = 16'h01BB;
  localparam logic [REG_W-1:0] CLR_ON_ONE    = 16'h000A;
  localparam logic [REG_W-1:0] ABSENT_WORD   = 16'hFF7F;

  // Software write: keep hardware-owned bits, take the rest, then clear-on-one.
  function automatic logic [REG_W-1:0] sw_merge(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] wd);
    logic [REG_W-1:0] v;
    v = (cur & HW_OWNED_MASK) | (wd & ~HW_OWNED_MASK);
    return v & ~(wd & CLR_ON_ONE);
  endfunction
endpackage

// File: rtl/rhp_port_slice.sv
module rhp_port_slice
  import rhp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wr_data,
  input  logic             present,
  input  logic             low_speed,
  input  logic             wakeup,
  output logic [REG_W-1:0] word_q,
  output logic             bus_reset_q,
  output logic             resume_q
);
  logic [REG_W-1:0] word_d;
  logic             pres_q;
  logic             attach, detach, upd;
  logic             bus_reset_d, resume_d;

  assign attach = present & ~pres_q;
  assign detach = ~present & pres_q;
  assign upd    = wr_hit | attach | detach | wakeup;

  always_comb begin
    word_d      = word_q;
    bus_reset_d = 1'b0;
    resume_d    = 1'b0;
    if (wr_hit) begin
      bus_reset_d = wr_data[B_BUSRST] & ~word_q[B_BUSRST];
      word_d      = sw_merge(word_q, wr_data);
    end
    if (attach) begin
      word_d[B_CONN]     = 1'b1;
      word_d[B_CONN_CHG] = 1'b1;
      word_d[B_LOWSPD]   = low_speed;
    end
    if (detach) begin
      if (word_d[B_CONN]) begin
        word_d[B_CONN]     = 1'b0;
        word_d[B_CONN_CHG] = 1'b1;
      end
      if (word_d[B_EN]) begin
        word_d[B_EN]     = 1'b0;
        word_d[B_EN_CHG] = 1'b1;
      end
    end
    if (wakeup && word_d[B_SUSP] && !word_d[B_RESUME]) begin
      word_d[B_RESUME] = 1'b1;
      resume_d         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= '0;
      pres_q      <= 1'b0;
      bus_reset_q <= 1'b0;
      resume_q    <= 1'b0;
    end else begin
      pres_q      <= present;
      bus_reset_q <= bus_reset_d;
      resume_q    <= resume_d;
      if (upd) word_q <= word_d;
    end
  end
endmodule

// File: rtl/rhp_read_mux.sv
module rhp_read_mux
  import rhp_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 3
)(
  input  logic [NUM_PORTS*REG_W-1:0] words,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [REG_W-1:0]           rd_data
);
  always_comb begin
    rd_data = ABSENT_WORD;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = words[i*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/rhp_root_ports.sv
module rhp_root_ports
  import rhp_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 3
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [15:0]          wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [15:0]          rd_data,
  input  logic [NUM_PORTS-1:0] dev_present,
  input  logic [NUM_PORTS-1:0] dev_low_speed,
  input  logic [NUM_PORTS-1:0] dev_wakeup,
  output logic [NUM_PORTS-1:0] bus_reset_pulse,
  output logic [NUM_PORTS-1:0] port_enabled,
  output logic                 resume_req
);
  localparam int WORDS_W = NUM_PORTS * REG_W;

  logic [WORDS_W-1:0]   words;
  logic [NUM_PORTS-1:0] resume_vec;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic [REG_W-1:0] w;
    rhp_port_slice u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (wr_en && (wr_idx == IDX_W'(g))),
      .wr_data     (wr_data),
      .present     (dev_present[g]),
      .low_speed   (dev_low_speed[g]),
      .wakeup      (dev_wakeup[g]),
      .word_q      (w),
      .bus_reset_q (bus_reset_pulse[g]),
      .resume_q    (resume_vec[g])
    );
    assign words[g*REG_W +: REG_W] = w;
    assign port_enabled[g]         = w[B_EN];
  end

  assign resume_req = |resume_vec;

  rhp_read_mux #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_rmux (
    .words   (words),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/rhp_root_ports_chk.sv
module rhp_root_ports_chk #(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 3
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic [IDX_W-1:0]     rd_idx,
  input logic [15:0]          rd_data,
  input logic [NUM_PORTS-1:0] dev_present,
  input logic [NUM_PORTS-1:0] dev_wakeup,
  input logic [NUM_PORTS-1:0] bus_reset_pulse,
  input logic [NUM_PORTS-1:0] port_enabled,
  input logic                 resume_req
);
  p_absent_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= NUM_PORTS) |-> (rd_data == 16'hFF7F));

  p_fixed_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) < NUM_PORTS) |-> (rd_data[7] == 1'b0 && rd_data[5:4] == 2'b00));

  p_resume_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past(|dev_wakeup));

  p_resume_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |=> !resume_req);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_pulse[i] |=> !bus_reset_pulse[i]);

    p_detach_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dev_present[i]) |=> !port_enabled[i]);

    p_enable_view_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == IDX_W'(i)) |-> (port_enabled[i] == rd_data[2]));
  end
endmodule

bind rhp_root_ports rhp_root_ports_chk #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_rhp_root_ports.sv
`timescale 1ns/1ps
module tb_rhp_root_ports;
  localparam int NP = 2;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [15:0]   wr_data, rd_data;
  logic [NP-1:0] dev_present, dev_low_speed, dev_wakeup, bus_reset_pulse, port_enabled;
  logic          resume_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rhp_root_ports #(.NUM_PORTS(NP), .IDX_W(IW)) dut (.*);

  typedef struct packed {
    logic [2:0]  idx;
    logic [15:0] wd;
    logic [15:0] exp;
  } vec_t;

  // Write wd to idx, then read idx back.
  localparam vec_t VEC [6] = '{
    '{3'd0, 16'hFFFF, 16'hFE45},  // R2 R3: hardware bits kept, change flags cleared
    '{3'd0, 16'h0000, 16'h0001},  // R2: writable bits drop to 0
    '{3'd1, 16'h0006, 16'h0105},  // R3 R1: clear connect change, set enable, low speed kept
    '{3'd1, 16'h0000, 16'h0101},  // R2
    '{3'd5, 16'hFFFF, 16'hFF7F},  // R8: absent index
    '{3'd0, 16'h01BB, 16'h0001}   // R2: writes to hardware bits ignored
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [15:0] exp);
    rd_idx = IW'(idx);
    #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wake(input int p);
    @(negedge clk);
    dev_wakeup[p] = 1'b1;
    @(negedge clk);
    dev_wakeup = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
    dev_present = '0; dev_low_speed = '0; dev_wakeup = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R10 reset port0", 0, 16'h0000);
    rd_chk("R10 reset port1", 1, 16'h0000);
    rd_chk("R8 absent read", 5, 16'hFF7F);
    chk("R10 pulses after reset", {14'd0, bus_reset_pulse}, 16'h0000);

    // R5 attach: port0 full speed, port1 low speed
    dev_present = 2'b11; dev_low_speed = 2'b10;
    @(negedge clk);
    rd_chk("R5 attach full speed", 0, 16'h0003);
    rd_chk("R5 attach low speed", 1, 16'h0103);

    foreach (VEC[i]) begin
      wr(int'(VEC[i].idx), VEC[i].wd);
      rd_chk($sformatf("R2 vector %0d", i), int'(VEC[i].idx), VEC[i].exp);
    end
    rd_chk("R8 absent write left port0", 0, 16'h0001);
    rd_chk("R8 absent write left port1", 1, 16'h0101);

    // R9 enable output
    wr(1, 16'h0004);
    chk("R9 enabled output", {14'd0, port_enabled}, 16'h0002);

    // R4 reset pulse on rising write
    wr(0, 16'h0200);
    chk("R4 pulse on rising write", {14'd0, bus_reset_pulse}, 16'h0001);
    rd_chk("R4 reset bit stored", 0, 16'h0201);
    @(negedge clk);
    chk("R4 pulse lasts one cycle", {14'd0, bus_reset_pulse}, 16'h0000);
    wr(0, 16'h0200);
    chk("R4 no pulse when already set", {14'd0, bus_reset_pulse}, 16'h0000);

    // R6 detach of an enabled port
    @(negedge clk);
    dev_present[1] = 1'b0;
    @(negedge clk);
    rd_chk("R6 detach word", 1, 16'h010A);
    chk("R6 R9 enable dropped", {14'd0, port_enabled}, 16'h0000);

    // R7 wakeup
    wake(0);
    chk("R7 no resume when awake", {15'd0, resume_req}, 16'h0000);
    rd_chk("R7 word unchanged when awake", 0, 16'h0201);
    wr(0, 16'h1000);
    rd_chk("R7 suspend set", 0, 16'h1001);
    wake(0);
    chk("R7 resume request", {15'd0, resume_req}, 16'h0001);
    rd_chk("R7 resume detect set", 0, 16'h1041);
    wake(0);
    chk("R7 no second resume", {15'd0, resume_req}, 16'h0000);

    // R11 write and detach in the same cycle: write enables, detach wins
    @(negedge clk);
    dev_present[1] = 1'b1;
    @(negedge clk);
    rd_chk("R11 reattach", 1, 16'h010B);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd1; wr_data = 16'h000E; dev_present[1] = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk("R11 detach after write", 1, 16'h010A);

    // R10 reset with port0 still present
    rst_n = 1'b0;
    @(negedge clk);
    rd_chk("R10 cleared in reset", 0, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R10 reattach after reset", 0, 16'h0003);
    rd_chk("R10 absent device stays clear", 1, 16'h0000);

    finish_run();
  end
endmodule